// File: doc/BRIEF.md
# Bit-Serial Half-Precision Floating-Point Adder

This block adds two half-precision floating-point numbers that arrive one bit per clock. Each operand uses two lines. One line carries the 11-bit significand, hidden bit included. The other carries the 5-bit exponent followed by the sign. Both lines are least-significant bit first, and a single-cycle start pulse marks bit 0 of an operand pair. Both operands share that pulse.

Once a frame has been collected, the block finds the operand with the larger magnitude and shifts the other one right to align it. The shifted value is rounded at that point, before any arithmetic. The block then adds or subtracts the aligned significands according to the signs. Finally it renormalises the sum and corrects the exponent. The result goes out on the same two-line format, framed by its own start pulse and a valid strobe. A new operand frame may begin on the cycle right after the previous one ends.

Top module: `fpas_serial_adder`

## Requirements
- R1: While reset is held, and until the first result frame, `out_start`, `out_valid`, `out_sig_bit` and `out_se_bit` are all 0.
- R2: Input start is sampled with bit 0 at edge n. The result frame then starts at edge n+11: `out_start` is high for one cycle and `out_valid` is high for 11 cycles. On `out_sig_bit`, cycle i carries significand bit i. On `out_se_bit`, cycles 0–4 carry exponent bits 0–4, cycle 5 carries the sign, and cycles 6–10 are 0.
- R3: The smaller-magnitude significand is shifted right by the exponent difference and rounded to nearest, ties to even. An equal exponent with an equal-or-larger significand counts as the larger magnitude.
- R4: When the exponents differ by more than 12, the smaller operand leaves the larger significand and exponent unchanged.
- R5: Equal signs add the significands. A sum of 2048 or more is shifted right by one and rounded to nearest-even on the dropped bit, and the exponent is incremented.
- R6: Opposite signs subtract the aligned smaller significand from the larger one. A nonzero difference is shifted left until bit 10 is 1, and the exponent drops by the shift count. Every result with a nonzero exponent therefore has its hidden bit set.
- R7: The result sign is the sign of the larger-magnitude operand. A zero difference is returned as +0: sign, exponent and significand all 0.
- R8: An exponent of 31 or more saturates to exponent 30 with significand 2047, keeping the sign. The output exponent is never 31.
- R9: An exponent of 0 or less is flushed to +0.
- R10: Frames sent back to back, with no idle cycle between them, each give their own correct result frame, also back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_start | input | 1 | High with bit 0 of an operand pair |
| a_sig_bit | input | 1 | Operand A significand, LSB first |
| a_se_bit | input | 1 | Operand A exponent bits 0–4, then sign |
| b_sig_bit | input | 1 | Operand B significand, LSB first |
| b_se_bit | input | 1 | Operand B exponent bits 0–4, then sign |
| out_start | output | 1 | High with bit 0 of a result |
| out_valid | output | 1 | High for the 11 bits of a result |
| out_sig_bit | output | 1 | Result significand, LSB first |
| out_se_bit | output | 1 | Result exponent bits 0–4, then sign, then zeros |

## Verification
The assertions take for granted that input start pulses are at least 11 cycles apart. They also take for granted that every operand is either an exact zero (exponent 0, significand 0) or a normal number: exponent 1 to 30 with the hidden bit set. Under those two conditions, every output exponent that is not 0 comes with the hidden bit set, a zero exponent comes with a positive sign, and the exponent never reaches 31. The stimulus spaces its frames 0 to 2 idle cycles apart and draws operands only from those two classes. The second operand's exponent is often placed within three of the first, so that ties, cancellations and carries occur often.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
   localparam int HP_SIG_W = 11;
   localparam int HP_EXP_W = 5;

   typedef enum logic {
      EFF_ADD = 1'b0,
      EFF_SUB = 1'b1
   } eff_op_e;
endpackage

// File: rtl/fpas_deser.sv
module fpas_deser #(
   parameter int W     = 11,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [IDX_W-1:0] idx,
   input  logic             din,
   output logic [W-1:0]     word
);
   logic en;
   assign en = take && (int'(idx) < W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
      end else if (en) begin
         word <= {din, word[W-1:1]};
      end
   end
endmodule

// File: rtl/fpas_align.sv
module fpas_align import fpas_pkg::*; #(
   parameter int SIG_W = 11,
   parameter int EXP_W = 5
) (
   input  logic [SIG_W-1:0] a_sig,
   input  logic [EXP_W-1:0] a_exp,
   input  logic             a_sgn,
   input  logic [SIG_W-1:0] b_sig,
   input  logic [EXP_W-1:0] b_exp,
   input  logic             b_sgn,
   output logic [SIG_W-1:0] big_sig,
   output logic [EXP_W-1:0] big_exp,
   output logic             big_sgn,
   output logic [SIG_W-1:0] small_al,
   output eff_op_e          op
);
   localparam int CAP   = SIG_W + 2;
   localparam int EXT_W = SIG_W + CAP;
   localparam int D_W   = $clog2(CAP + 1);

   logic             a_big;
   logic [SIG_W-1:0] sm_sig;
   logic [EXP_W-1:0] sm_exp;
   logic [EXP_W-1:0] diff;
   logic [D_W-1:0]   sh;
   logic [EXT_W-1:0] ext;
   logic [SIG_W-1:0] intp;
   logic             guard, sticky, rnd;

   assign a_big   = (a_exp > b_exp) || ((a_exp == b_exp) && (a_sig >= b_sig));
   assign big_sig = a_big ? a_sig : b_sig;
   assign big_exp = a_big ? a_exp : b_exp;
   assign big_sgn = a_big ? a_sgn : b_sgn;
   assign sm_sig  = a_big ? b_sig : a_sig;
   assign sm_exp  = a_big ? b_exp : a_exp;
   assign op      = (a_sgn ^ b_sgn) ? EFF_SUB : EFF_ADD;

   assign diff   = big_exp - sm_exp;
   assign sh     = (int'(diff) > CAP) ? D_W'(CAP) : D_W'(diff);
   assign ext    = {sm_sig, {CAP{1'b0}}} >> sh;
   assign intp   = ext[EXT_W-1:CAP];
   assign guard  = ext[CAP-1];
   assign sticky = |ext[CAP-2:0];
   assign rnd    = guard & (sticky | intp[0]);
   assign small_al = intp + SIG_W'(rnd);
endmodule

// File: rtl/fpas_norm.sv
module fpas_norm #(
   parameter int SIG_W = 11,
   parameter int EXP_W = 5
) (
   input  logic [SIG_W:0]   sum,
   input  logic [EXP_W-1:0] big_exp,
   input  logic             big_sgn,
   output logic [SIG_W-1:0] res_sig,
   output logic [EXP_W-1:0] res_exp,
   output logic             res_sgn
);
   localparam int LZ_W = $clog2(SIG_W + 1);
   localparam int E_W  = EXP_W + 2;
   localparam int EMAX = (1 << EXP_W) - 1;

   logic [LZ_W-1:0]        lz;
   logic signed [E_W-1:0]  e_n;
   logic [SIG_W-1:0]       m_n;

   always_comb begin
      lz = LZ_W'(SIG_W);
      for (int i = 0; i < SIG_W; i++) begin
         if (sum[i]) lz = LZ_W'(SIG_W - 1 - i);
      end
   end

   always_comb begin
      if (sum[SIG_W]) begin
         m_n = sum[SIG_W:1] + SIG_W'(sum[0] & sum[1]);
         e_n = signed'(E_W'(big_exp)) + E_W'(1);
      end else begin
         m_n = sum[SIG_W-1:0] << lz;
         e_n = signed'(E_W'(big_exp)) - signed'(E_W'(lz));
      end
      if ((sum == '0) || (e_n <= 0)) begin
         res_sig = '0;
         res_exp = '0;
         res_sgn = 1'b0;
      end else if (e_n >= E_W'(EMAX)) begin
         res_sig = '1;
         res_exp = EXP_W'(EMAX - 1);
         res_sgn = big_sgn;
      end else begin
         res_sig = m_n;
         res_exp = EXP_W'(e_n);
         res_sgn = big_sgn;
      end
   end
endmodule

// File: rtl/fpas_ser.sv
module fpas_ser #(
   parameter int SIG_W = 11,
   parameter int SE_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SIG_W-1:0] sig_word,
   input  logic [SE_W-1:0]  se_word,
   output logic             out_start,
   output logic             out_valid,
   output logic             out_sig_bit,
   output logic             out_se_bit
);
   localparam int CNT_W = $clog2(SIG_W);

   logic [SIG_W-1:0] sig_q;
   logic [SE_W-1:0]  se_q;
   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sig_q     <= '0;
         se_q      <= '0;
         rem_q     <= '0;
         out_start <= 1'b0;
         out_valid <= 1'b0;
      end else if (load) begin
         sig_q     <= sig_word;
         se_q      <= se_word;
         rem_q     <= CNT_W'(SIG_W - 1);
         out_start <= 1'b1;
         out_valid <= 1'b1;
      end else begin
         sig_q     <= sig_q >> 1;
         se_q      <= se_q >> 1;
         out_start <= 1'b0;
         if (rem_q != '0) rem_q <= rem_q - CNT_W'(1);
         else             out_valid <= 1'b0;
      end
   end

   assign out_sig_bit = sig_q[0];
   assign out_se_bit  = se_q[0];
endmodule

// File: rtl/fpas_serial_adder.sv
module fpas_serial_adder import fpas_pkg::*; #(
   parameter int SIG_W = HP_SIG_W,
   parameter int EXP_W = HP_EXP_W
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_start,
   input  logic a_sig_bit,
   input  logic a_se_bit,
   input  logic b_sig_bit,
   input  logic b_se_bit,
   output logic out_start,
   output logic out_valid,
   output logic out_sig_bit,
   output logic out_se_bit
);
   localparam int SE_W  = EXP_W + 1;
   localparam int FRAME = SIG_W;
   localparam int IDX_W = $clog2(FRAME);

   if (SIG_W < 4) begin : g_bad_sig
      $error("fpas_serial_adder: SIG_W must be at least 4");
   end
   if (SE_W > FRAME) begin : g_bad_frame
      $error("fpas_serial_adder: sign/exponent stream longer than frame");
   end
   if (EXP_W < $clog2(SIG_W + 3)) begin : g_bad_exp
      $error("fpas_serial_adder: EXP_W too narrow for shift cap");
   end

   logic [IDX_W-1:0] idx_q, cur_idx;
   logic             busy_q, rdy_q, take, last;

   assign cur_idx = in_start ? '0 : idx_q;
   assign take    = in_start | busy_q;
   assign last    = (cur_idx == IDX_W'(FRAME - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         busy_q <= 1'b0;
         rdy_q  <= 1'b0;
      end else begin
         rdy_q <= take && last;
         if (take) begin
            busy_q <= !last;
            idx_q  <= last ? '0 : cur_idx + IDX_W'(1);
         end
      end
   end

   logic [1:0]       sig_lines, se_lines;
   logic [SIG_W-1:0] op_sig [2];
   logic [SE_W-1:0]  op_se  [2];

   assign sig_lines = {b_sig_bit, a_sig_bit};
   assign se_lines  = {b_se_bit,  a_se_bit};

   for (genvar g = 0; g < 2; g++) begin : g_op
      fpas_deser #(.W(SIG_W), .IDX_W(IDX_W)) u_sig (
         .clk(clk), .rst_n(rst_n), .take(take), .idx(cur_idx),
         .din(sig_lines[g]), .word(op_sig[g]));
      fpas_deser #(.W(SE_W), .IDX_W(IDX_W)) u_se (
         .clk(clk), .rst_n(rst_n), .take(take), .idx(cur_idx),
         .din(se_lines[g]), .word(op_se[g]));
   end

   logic [SIG_W-1:0] big_sig, small_al, res_sig;
   logic [EXP_W-1:0] big_exp, res_exp;
   logic             big_sgn, res_sgn;
   eff_op_e          op;
   logic [SIG_W:0]   sum;

   fpas_align #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_align (
      .a_sig(op_sig[0]), .a_exp(op_se[0][EXP_W-1:0]), .a_sgn(op_se[0][EXP_W]),
      .b_sig(op_sig[1]), .b_exp(op_se[1][EXP_W-1:0]), .b_sgn(op_se[1][EXP_W]),
      .big_sig(big_sig), .big_exp(big_exp), .big_sgn(big_sgn),
      .small_al(small_al), .op(op));

   assign sum = (op == EFF_SUB) ? ({1'b0, big_sig} - {1'b0, small_al})
                                : ({1'b0, big_sig} + {1'b0, small_al});

   fpas_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_norm (
      .sum(sum), .big_exp(big_exp), .big_sgn(big_sgn),
      .res_sig(res_sig), .res_exp(res_exp), .res_sgn(res_sgn));

   fpas_ser #(.SIG_W(SIG_W), .SE_W(SE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(rdy_q),
      .sig_word(res_sig), .se_word({res_sgn, res_exp}),
      .out_start(out_start), .out_valid(out_valid),
      .out_sig_bit(out_sig_bit), .out_se_bit(out_se_bit));
endmodule

// File: rtl/fpas_checker.sv
module fpas_checker #(
   parameter int SIG_W = 11,
   parameter int EXP_W = 5
) (
   input logic clk,
   input logic rst_n,
   input logic out_start,
   input logic out_valid,
   input logic out_sig_bit,
   input logic out_se_bit
);
   localparam int VC_W = $clog2(SIG_W) + 1;

   logic [VC_W-1:0] vcnt;
   logic            e_nz, e_all;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vcnt  <= '0;
         e_nz  <= 1'b0;
         e_all <= 1'b0;
      end else begin
         if (out_start) begin
            vcnt  <= VC_W'(1);
            e_nz  <= out_se_bit;
            e_all <= out_se_bit;
         end else begin
            if (vcnt != '0 && int'(vcnt) < SIG_W - 1) vcnt <= vcnt + VC_W'(1);
            else                                      vcnt <= '0;
            if (vcnt != '0 && int'(vcnt) < EXP_W) begin
               e_nz  <= e_nz | out_se_bit;
               e_all <= e_all & out_se_bit;
            end
         end
      end
   end

   AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid); // R2
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |=> !out_start); // R2
   AST_VALID_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (vcnt != '0) |-> out_valid); // R2
   AST_VALID_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_start || vcnt != '0)); // R2
   AST_SE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_start && int'(vcnt) > EXP_W) |-> !out_se_bit); // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_start && int'(vcnt) == EXP_W) |-> !e_all); // R8
   AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_start && int'(vcnt) == EXP_W && !e_nz) |-> !out_se_bit); // R7
   AST_HIDDEN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_start && int'(vcnt) == SIG_W - 1) |-> (out_sig_bit == e_nz)); // R6
endmodule

bind fpas_serial_adder fpas_checker #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_start(out_start), .out_valid(out_valid),
   .out_sig_bit(out_sig_bit), .out_se_bit(out_se_bit));

// File: tb/fpas_serial_adder_bench.sv
module fpas_serial_adder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAXC       = 4096;
   localparam int LAT        = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_start = 1'b0;
   logic a_sig_bit = 1'b0, a_se_bit = 1'b0, b_sig_bit = 1'b0, b_se_bit = 1'b0;
   logic out_start, out_valid, out_sig_bit, out_se_bit;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit run_chk = 1'b0;

   bit    e_v [MAXC];
   bit    e_s [MAXC];
   bit    e_m [MAXC];
   bit    e_x [MAXC];
   string e_tag [MAXC];

   fpas_serial_adder u_fpas_serial_adder (
      .clk(clk), .rst_n(rst_n), .in_start(in_start),
      .a_sig_bit(a_sig_bit), .a_se_bit(a_se_bit),
      .b_sig_bit(b_sig_bit), .b_se_bit(b_se_bit),
      .out_start(out_start), .out_valid(out_valid),
      .out_sig_bit(out_sig_bit), .out_se_bit(out_se_bit));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [16:0] ref_add(logic [10:0] as, logic [5:0] ase,
                                           logic [10:0] bs, logic [5:0] bse);
      int ea = int'(ase[4:0]);
      int eb = int'(bse[4:0]);
      longint ma = longint'(as);
      longint mb = longint'(bs);
      int el, es, d, e;
      longint ml, ms, al, s, q, r, h, m;
      bit sl;
      if (ea > eb || (ea == eb && ma >= mb)) begin
         el = ea; ml = ma; sl = ase[5]; es = eb; ms = mb;
      end else begin
         el = eb; ml = mb; sl = bse[5]; es = ea; ms = ma;
      end
      d = el - es;
      if (d > 12) al = 0;
      else if (d == 0) al = ms;
      else begin
         q = ms >> d;
         r = ms - (q << d);
         h = longint'(1) << (d - 1);
         al = q;
         if (r > h || (r == h && (q % 2) == 1)) al = q + 1;
      end
      s = (ase[5] == bse[5]) ? ml + al : ml - al;
      e = el;
      if (s == 0) return 17'd0;
      if (s >= 2048) begin
         m = s >> 1;
         if ((s % 2) == 1 && (m % 2) == 1) m = m + 1;
         e = e + 1;
      end else begin
         while (s < 1024) begin s = s * 2; e = e - 1; end
         m = s;
      end
      if (e <= 0) return 17'd0;
      if (e >= 31) return {sl, 5'd30, 11'h7ff};
      return {sl, 5'(e), 11'(m)};
   endfunction

   // Per-cycle comparison of all four outputs with the scheduled expectation
   always @(negedge clk) begin
      if (run_chk && cyc < MAXC) begin
         checks++;
         if ({out_valid, out_start, out_sig_bit, out_se_bit} !==
             {e_v[cyc], e_s[cyc], e_m[cyc], e_x[cyc]}) begin
            fails++;
            $display("FAIL %s cycle %0d: actual v/s/sig/se=%b%b%b%b expected=%b%b%b%b",
                     e_tag[cyc], cyc, out_valid, out_start, out_sig_bit, out_se_bit,
                     e_v[cyc], e_s[cyc], e_m[cyc], e_x[cyc]);
         end
      end
   end

   task automatic send(input logic [10:0] as, input logic [5:0] ase,
                       input logic [10:0] bs, input logic [5:0] bse,
                       input string tag, input int gap);
      logic [16:0] res;
      int base;
      base = cyc;
      res  = ref_add(as, ase, bs, bse);
      if (base + LAT + 11 < MAXC) begin
         for (int i = 0; i < 11; i++) begin
            e_v[base+LAT+i]   = 1'b1;
            e_s[base+LAT+i]   = (i == 0);
            e_m[base+LAT+i]   = res[i];
            e_x[base+LAT+i]   = (i < 6) ? res[11+i] : 1'b0;
            e_tag[base+LAT+i] = tag;
         end
      end
      for (int i = 0; i < 11; i++) begin
         in_start  = (i == 0);
         a_sig_bit = as[i];
         b_sig_bit = bs[i];
         a_se_bit  = (i < 6) ? ase[i] : 1'b0;
         b_se_bit  = (i < 6) ? bse[i] : 1'b0;
         @(negedge clk);
      end
      in_start = 1'b0; a_sig_bit = 1'b0; b_sig_bit = 1'b0; a_se_bit = 1'b0; b_se_bit = 1'b0;
      for (int i = 0; i < gap; i++) @(negedge clk);
   endtask

   task automatic rand_op(input int near, output logic [10:0] sg, output logic [5:0] se);
      int e;
      if ($urandom % 16 == 0) begin
         sg = '0; se = '0;
      end else begin
         e = (near > 0) ? near + int'($urandom % 7) - 3 : 1 + int'($urandom % 30);
         if (e < 1) e = 1;
         if (e > 30) e = 30;
         sg = 11'h400 | 11'($urandom % 1024);
         se = {1'($urandom % 2), 5'(e)};
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [10:0] as, bs;
      logic [5:0]  ase, bse;
      for (int i = 0; i < MAXC; i++) e_tag[i] = "R2 idle";
      repeat (3) @(negedge clk);
      checks++; // R1 reset state
      if ({out_valid, out_start, out_sig_bit, out_se_bit} !== 4'b0000) begin
         fails++;
         $display("FAIL R1 reset: actual=%b%b%b%b expected=0000",
                  out_valid, out_start, out_sig_bit, out_se_bit);
      end
      rst_n = 1'b1;
      run_chk = 1'b1;
      @(negedge clk);
      // R3: diff 2, tie with odd quotient rounds up
      send(11'd1024, {1'b0, 5'd15}, 11'd1030, {1'b0, 5'd13}, "R3 tie-even", 2);
      send(11'd1024, {1'b0, 5'd15}, 11'd1026, {1'b0, 5'd13}, "R3 tie-even low", 1);
      // R4: far-apart exponents
      send(11'd1500, {1'b0, 5'd20}, 11'd2047, {1'b1, 5'd5}, "R4 diff 15", 1);
      send(11'd1500, {1'b0, 5'd20}, 11'd2047, {1'b0, 5'd8}, "R4 diff 12", 1);
      send(11'd1500, {1'b0, 5'd20}, 11'd2047, {1'b0, 5'd9}, "R3 diff 11", 1);
      // R5: carry-out renormalisation
      send(11'd2047, {1'b0, 5'd15}, 11'd2047, {1'b0, 5'd15}, "R5 carry", 1);
      send(11'd2045, {1'b1, 5'd15}, 11'd2046, {1'b1, 5'd15}, "R5 carry round", 1);
      // R6: cancellation
      send(11'd1025, {1'b0, 5'd15}, 11'd1024, {1'b1, 5'd15}, "R6 cancel", 1);
      send(11'd1024, {1'b1, 5'd16}, 11'd1800, {1'b0, 5'd15}, "R6 sub sign", 1);
      // R7: exact zero and sign of larger
      send(11'd1300, {1'b1, 5'd10}, 11'd1300, {1'b0, 5'd10}, "R7 zero", 1);
      send(11'd0, {1'b1, 5'd0}, 11'd0, {1'b1, 5'd0}, "R7 neg zeros", 1);
      send(11'd1100, {1'b0, 5'd12}, 11'd1900, {1'b1, 5'd12}, "R7 sign", 1);
      // R8: saturation
      send(11'd2047, {1'b1, 5'd30}, 11'd2047, {1'b1, 5'd30}, "R8 saturate", 1);
      // R9: underflow flush
      send(11'd1025, {1'b0, 5'd3}, 11'd1024, {1'b1, 5'd3}, "R9 flush", 1);
      // R10: back-to-back
      send(11'd1111, {1'b0, 5'd14}, 11'd1222, {1'b0, 5'd14}, "R10 first", 0);
      send(11'd1333, {1'b1, 5'd17}, 11'd1444, {1'b0, 5'd16}, "R10 second", 0);
      send(11'd1555, {1'b0, 5'd9}, 11'd1666, {1'b1, 5'd11}, "R10 third", 2);
      // Random operand pairs
      for (int k = 0; k < 150; k++) begin
         rand_op(0, as, ase);
         rand_op(($urandom % 2 == 0) ? int'(ase[4:0]) : 0, bs, bse);
         send(as, ase, bs, bse, "R3,R5,R6,R7 random", int'($urandom % 3));
      end
      repeat (LAT + 14) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule